// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block holds the interrupt control register of a small 8-bit microcontroller whose instruction cycle is split into four clock phases, Q1 to Q4. It watches three interrupt sources: an external pin with a selectable active edge, a one-clock timer rollover strobe, and the upper four pins of an 8-bit port, which are compared against a reference value that a port read captures. Each source sets its own flag bit. The flags are combined with their enables and a global enable to start the vector entry sequence. While the core sleeps, the block also raises a wake signal.

The clock input runs at the phase rate, so four clocks make one instruction cycle. The block keeps its own phase counter and reports the current phase on an output. Asynchronous pins pass through a two-stage synchronizer before any edge or change is detected. The block checks the flag-and-enable state once per instruction cycle, at Q1. When an interrupt is taken, the block clears the global enable, requests one dummy instruction cycle, and then requests the vector fetch at a fixed address.

Top module: `irq_flag_ctrl`

## Requirements
- R1: In the control register, bit 1 is the external flag, and a detected external pin edge sets it. With edge_rising = 1 only a 0-to-1 change of the pin counts; with edge_rising = 0 only a 1-to-0 change counts.
- R2: The external flag is set only on the clock edge that ends Q4 or Q1; an edge found in Q2 or Q3 is held back until the end of Q4. A pin change driven during Q1 first shows in the flag in the next Q1, and one driven during Q3 first shows in the next Q2. Phases are encoded as 0 = Q1, 1 = Q2, 2 = Q3, 3 = Q4.
- R3: A one-clock high pulse on tmr_ovf sets bit 2, the timer flag, on that clock edge, whatever the phase.
- R4: Bit 0, the port-change flag, is set on every clock while the synchronized port_hi differs from the stored reference. The reference is loaded only when port_rd is high during Q2; port_rd in any other phase has no effect.
- R5: On the clock where a Q2 port read loads the reference, the port-change flag is not set. So a pin change that reaches the synchronizer output during that read is lost.
- R6: A register write loads the global enable (bit 7), the timer enable (bit 5), the external enable (bit 4) and the port-change enable (bit 3). A 0 written to a flag bit (bits 2..0) clears it, and a 1 leaves it as it was. A hardware set on the same clock wins. Bit 6 always reads 0.
- R7: If bit 7 is 1 and any flag is 1 together with its enable during Q1 of cycle k, then at the end of that Q1 bit 7 is cleared by hardware. dummy_cycle is then high for all four phases of cycle k+1 and vec_req for all four phases of cycle k+2. vec_addr is always 0x0004.
- R8: wake equals asleep AND (any flag together with its enable), independent of bit 7. With bit 7 clear, no vector sequence starts.
- R9: After reset the control register reads 0x00, and vec_req, dummy_cycle and wake are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, four per instruction cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| edge_rising | input | 1 | 1 selects the rising edge of ext_pin, 0 the falling edge |
| tmr_ovf | input | 1 | One-clock timer rollover strobe |
| port_hi | input | 4 | Asynchronous upper port pins |
| port_rd | input | 1 | Port read strobe, effective in Q2 only |
| reg_we | input | 1 | Control register write enable |
| reg_wdata | input | 8 | Control register write data |
| asleep | input | 1 | Core is in sleep |
| ctrl_rd | output | 8 | Control register contents |
| phase | output | 2 | Current phase, 0 = Q1 .. 3 = Q4 |
| vec_req | output | 1 | Vector fetch request cycle |
| vec_addr | output | 13 | Interrupt vector address |
| dummy_cycle | output | 1 | Dummy instruction cycle request |
| wake | output | 1 | Wake request for the sleeping core |

## Verification
The assertions check the following on every cycle:
- The external flag only ever rises in Q1 or Q2.
- A dummy cycle always starts in Q1 with the global enable already cleared.
- The vector request follows directly on the dummy cycle and never overlaps it.
- wake never appears while the core is awake.

Only the bench scenarios can show the rest:
- The exact phase at which each source's flag becomes visible.
- The three-cycle latency from a timer strobe to the vector request.
- The port change lost during a Q2 read.
- That reads in other phases leave the reference unchanged.
- That wake-up happens without vectoring when the global enable is clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int PHASE_W = 2;
    localparam int REG_W   = 8;

    localparam int BIT_GIE = 7;
    localparam int BIT_UNU = 6;
    localparam int BIT_TIE = 5;
    localparam int BIT_XIE = 4;
    localparam int BIT_PIE = 3;
    localparam int BIT_TIF = 2;
    localparam int BIT_XIF = 1;
    localparam int BIT_PIF = 0;

    typedef enum logic [PHASE_W-1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_WAIT   = 2'd1,
        SEQ_DUMMY  = 2'd2,
        SEQ_VECTOR = 2'd3
    } seq_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int CHAIN_W = WIDTH * STAGES;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_state_t;

    sync_state_t state_d, state_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                state_d.chain = din;
            end
        end else begin : g_multi
            always_comb begin
                state_d.chain = {state_q.chain[CHAIN_W-WIDTH-1:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign dout = state_q.chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/irq_edge_unit.sv
module irq_edge_unit
    import irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_sync,
    input  logic   rising_sel,
    input  phase_t phase,
    output logic   set_flag
);
    typedef struct packed {
        logic prev;
        logic pend;
    } edge_state_t;

    edge_state_t state_d, state_q;
    logic        detected;
    logic        window;

    always_comb begin
        state_d      = state_q;
        detected     = rising_sel ? (pin_sync & ~state_q.prev)
                                  : (~pin_sync & state_q.prev);
        window       = (phase == PH_Q4) || (phase == PH_Q1);
        set_flag     = window & (detected | state_q.pend);
        state_d.pend = ~window & (detected | state_q.pend);
        state_d.prev = pin_sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/irq_port_change.sv
module irq_port_change
    import irq_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] port_sync,
    input  logic             rd_strobe,
    input  phase_t           phase,
    output logic             set_flag
);
    typedef struct packed {
        logic [WIDTH-1:0] ref_val;
    } port_state_t;

    port_state_t state_d, state_q;
    logic        rd_eff;

    always_comb begin
        state_d = state_q;
        rd_eff  = rd_strobe && (phase == PH_Q2);
        if (rd_eff) state_d.ref_val = port_sync;
        set_flag = ~rd_eff && (port_sync != state_q.ref_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq
    import irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t phase,
    input  logic   pending,
    output logic   take,
    output logic   dummy,
    output logic   vector
);
    typedef struct packed {
        seq_t st;
    } seq_state_t;

    seq_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        take    = (state_q.st == SEQ_IDLE) && (phase == PH_Q1) && pending;
        if (take) begin
            state_d.st = SEQ_WAIT;
        end else if (phase == PH_Q4) begin
            case (state_q.st)
                SEQ_WAIT:   state_d.st = SEQ_DUMMY;
                SEQ_DUMMY:  state_d.st = SEQ_VECTOR;
                SEQ_VECTOR: state_d.st = SEQ_IDLE;
                default:    state_d.st = state_q.st;
            endcase
        end
        dummy  = (state_q.st == SEQ_DUMMY);
        vector = (state_q.st == SEQ_VECTOR);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '{st: SEQ_IDLE};
        else        state_q <= state_d;
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_pkg::*;
#(
    parameter int              PORT_W      = 4,
    parameter int              SYNC_STAGES = 2,
    parameter int              VEC_W       = 13,
    parameter logic [VEC_W-1:0] VEC_ADDR   = 13'h0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic              edge_rising,
    input  logic              tmr_ovf,
    input  logic [PORT_W-1:0] port_hi,
    input  logic              port_rd,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    input  logic              asleep,
    output logic [7:0]        ctrl_rd,
    output logic [1:0]        phase,
    output logic              vec_req,
    output logic [VEC_W-1:0]  vec_addr,
    output logic              dummy_cycle,
    output logic              wake
);
    localparam int SYNC_W = PORT_W + 1;

    typedef struct packed {
        phase_t ph;
        logic   gie;
        logic   tie;
        logic   xie;
        logic   pie;
        logic   tif;
        logic   xif;
        logic   pif;
    } top_state_t;

    top_state_t        state_d, state_q;
    logic [SYNC_W-1:0] sync_out;
    logic              ext_set, port_set, take, any_irq, pending;

    irq_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ext_pin, port_hi}),
        .dout (sync_out)
    );

    irq_edge_unit u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_sync  (sync_out[SYNC_W-1]),
        .rising_sel(edge_rising),
        .phase     (state_q.ph),
        .set_flag  (ext_set)
    );

    irq_port_change #(.WIDTH(PORT_W)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_sync(sync_out[PORT_W-1:0]),
        .rd_strobe(port_rd),
        .phase    (state_q.ph),
        .set_flag (port_set)
    );

    irq_vector_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase  (state_q.ph),
        .pending(pending),
        .take   (take),
        .dummy  (dummy_cycle),
        .vector (vec_req)
    );

    always_comb begin
        state_d    = state_q;
        state_d.ph = phase_t'(state_q.ph + 2'd1);
        any_irq    = (state_q.tif & state_q.tie) |
                     (state_q.xif & state_q.xie) |
                     (state_q.pif & state_q.pie);
        pending    = state_q.gie & any_irq;
        if (reg_we) begin
            state_d.gie = reg_wdata[BIT_GIE];
            state_d.tie = reg_wdata[BIT_TIE];
            state_d.xie = reg_wdata[BIT_XIE];
            state_d.pie = reg_wdata[BIT_PIE];
            state_d.tif = state_q.tif & reg_wdata[BIT_TIF];
            state_d.xif = state_q.xif & reg_wdata[BIT_XIF];
            state_d.pif = state_q.pif & reg_wdata[BIT_PIF];
        end
        if (take)     state_d.gie = 1'b0;
        if (tmr_ovf)  state_d.tif = 1'b1;
        if (ext_set)  state_d.xif = 1'b1;
        if (port_set) state_d.pif = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '{ph: PH_Q1, default: 1'b0};
        else        state_q <= state_d;
    end

    always_comb begin
        ctrl_rd          = '0;
        ctrl_rd[BIT_GIE] = state_q.gie;
        ctrl_rd[BIT_UNU] = 1'b0;
        ctrl_rd[BIT_TIE] = state_q.tie;
        ctrl_rd[BIT_XIE] = state_q.xie;
        ctrl_rd[BIT_PIE] = state_q.pie;
        ctrl_rd[BIT_TIF] = state_q.tif;
        ctrl_rd[BIT_XIF] = state_q.xif;
        ctrl_rd[BIT_PIF] = state_q.pif;
    end

    assign phase    = state_q.ph;
    assign vec_addr = VEC_ADDR;
    assign wake     = asleep & any_irq;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctrl_rd,
    input logic [1:0] phase,
    input logic       vec_req,
    input logic       dummy_cycle,
    input logic       wake,
    input logic       asleep
);
    assert_ext_flag_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_rd[1]) |-> (phase == 2'd0 || phase == 2'd1));

    assert_dummy_starts_q1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dummy_cycle) |-> (phase == 2'd0 && !ctrl_rd[7]));

    assert_vector_follows_dummy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dummy_cycle) |-> vec_req);

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dummy_cycle && vec_req));

    assert_wake_only_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> asleep);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_rd    (ctrl_rd),
    .phase      (phase),
    .vec_req    (vec_req),
    .dummy_cycle(dummy_cycle),
    .wake       (wake),
    .asleep     (asleep)
);

// File: tb/irq_flag_ctrl_test.sv
module irq_flag_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n, ext_pin, edge_rising, tmr_ovf, port_rd, reg_we, asleep;
    logic [3:0]  port_hi;
    logic [7:0]  reg_wdata, ctrl_rd;
    logic [1:0]  phase;
    logic        vec_req, dummy_cycle, wake;
    logic [12:0] vec_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic       m_gie, m_tie, m_xie, m_pie, m_tif, m_xif, m_pif;
    logic [3:0] m_ref;

    always #2 clk = ~clk;

    irq_flag_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .edge_rising(edge_rising),
        .tmr_ovf(tmr_ovf), .port_hi(port_hi), .port_rd(port_rd), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .asleep(asleep), .ctrl_rd(ctrl_rd), .phase(phase),
        .vec_req(vec_req), .vec_addr(vec_addr), .dummy_cycle(dummy_cycle), .wake(wake)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_phase(input logic [1:0] p);
        do @(negedge clk); while (phase != p);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic q2_read();
        wait_phase(2'd1);
        port_rd = 1'b1;
        @(negedge clk);
        port_rd = 1'b0;
    endtask

    function automatic logic [7:0] model_reg();
        return {m_gie, 1'b0, m_tie, m_xie, m_pie, m_tif, m_xif, m_pif};
    endfunction

    function automatic logic model_wake();
        return asleep & ((m_tif & m_tie) | (m_xif & m_xie) | (m_pif & m_pie));
    endfunction

    initial begin
        #800000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ext_pin = 0; edge_rising = 1; tmr_ovf = 0; port_hi = 0;
        port_rd = 0; reg_we = 0; reg_wdata = 0; asleep = 0;
        tick(4);
        rst_n = 1;
        tick(1);
        chk("R9 reset reg", ctrl_rd, 8'h00);
        chk("R9 reset outputs", {vec_req, dummy_cycle, wake}, 3'b000);
        chk("R7 vector address", vec_addr, 13'h0004);

        // R1/R2: rising edge driven in Q1, seen in next Q1
        wait_phase(2'd0);
        ext_pin = 1'b1;
        tick(1); chk("R2 ext Q2", ctrl_rd[1], 1'b0);
        tick(1); chk("R2 ext Q3", ctrl_rd[1], 1'b0);
        tick(1); chk("R2 ext Q4", ctrl_rd[1], 1'b0);
        tick(1); chk("R1 ext rising sets", ctrl_rd[1], 1'b1);
        wr(8'h00);
        tick(2);
        chk("R6 write 0 clears", ctrl_rd, 8'h00);

        // falling edge driven in Q3, seen in Q2
        edge_rising = 1'b0;
        wait_phase(2'd2);
        ext_pin = 1'b0;
        tick(1); chk("R2 ext fall Q4", ctrl_rd[1], 1'b0);
        tick(1); chk("R2 ext fall Q1", ctrl_rd[1], 1'b0);
        tick(1); chk("R1 ext falling sets Q2", ctrl_rd[1], 1'b1);
        wr(8'h00);
        ext_pin = 1'b1;
        tick(12);
        chk("R1 wrong polarity ignored", ctrl_rd[1], 1'b0);

        // R3/R7: timer strobe in Q4 and vector sequence
        wr(8'hA0);
        wait_phase(2'd3);
        tmr_ovf = 1'b1;
        tick(1);
        tmr_ovf = 1'b0;
        chk("R3 timer flag", ctrl_rd[2], 1'b1);
        chk("R7 no dummy yet", dummy_cycle, 1'b0);
        tick(1);
        chk("R7 gie cleared", ctrl_rd[7], 1'b0);
        tick(2);
        chk("R7 wait cycle", {dummy_cycle, vec_req}, 2'b00);
        for (int i = 0; i < 4; i++) begin
            tick(1); chk("R7 dummy cycle", {dummy_cycle, vec_req}, 2'b10);
        end
        for (int i = 0; i < 4; i++) begin
            tick(1); chk("R7 vector cycle", {dummy_cycle, vec_req}, 2'b01);
        end
        tick(1); chk("R7 sequence done", {dummy_cycle, vec_req}, 2'b00);
        wr(8'h00);

        // R5: change reaching sync output during Q2 read is lost
        wait_phase(2'd3);
        port_hi = 4'h1;
        tick(2);
        port_rd = 1'b1;
        tick(1);
        port_rd = 1'b0;
        tick(12);
        chk("R5 missed port change", ctrl_rd[0], 1'b0);

        // R4: mismatch sets; non-Q2 read leaves reference
        port_hi = 4'h3;
        tick(12);
        chk("R4 port change sets", ctrl_rd[0], 1'b1);
        q2_read();
        wr(8'h00);
        tick(2);
        chk("R4 Q2 read reloads ref", ctrl_rd[0], 1'b0);
        port_hi = 4'h7;
        tick(8);
        wait_phase(2'd3);
        port_rd = 1'b1;
        tick(1);
        port_rd = 1'b0;
        wr(8'h00);
        tick(2);
        chk("R4 Q4 read ignored", ctrl_rd[0], 1'b1);
        q2_read();
        wr(8'h00);

        // R6: writing ones to flags and bit 6 has no effect
        wr(8'h47);
        tick(2);
        chk("R6 write ones ignored", ctrl_rd, 8'h00);

        // R8: wake without global enable
        wr(8'h10);
        asleep = 1'b1;
        tick(1);
        chk("R8 no wake idle", wake, 1'b0);
        edge_rising = 1'b0;
        ext_pin = 1'b0;
        for (int i = 0; i < 16; i++) begin
            tick(1); chk("R8 no vector without gie", vec_req | dummy_cycle, 1'b0);
        end
        chk("R8 wake raised", wake, 1'b1);
        wr(8'h00);
        edge_rising = 1'b1;
        ext_pin = 1'b1;
        tick(12);
        chk("R8 flag without enable", ctrl_rd[1], 1'b1);
        chk("R8 no wake disabled", wake, 1'b0);
        wr(8'h00);
        tick(2);

        // random phase: model with gie held 0
        void'($urandom(32'd4711));
        m_gie = 0; m_tie = 0; m_xie = 0; m_pie = 0; m_tif = 0; m_xif = 0; m_pif = 0;
        m_ref = port_hi;
        for (int it = 0; it < 300; it++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0: begin
                    logic nv;
                    edge_rising = 1'($urandom);
                    nv = ~ext_pin;
                    ext_pin = nv;
                    if (nv == edge_rising) m_xif = 1'b1;
                end
                1: begin
                    port_hi = 4'($urandom);
                    if (port_hi != m_ref) m_pif = 1'b1;
                end
                2: begin
                    tmr_ovf = 1'b1; tick(1); tmr_ovf = 1'b0;
                    m_tif = 1'b1;
                end
                3: begin
                    q2_read();
                    m_ref = port_hi;
                end
                4: begin
                    logic [7:0] d;
                    d = 8'($urandom) & 8'h7F;
                    wr(d);
                    m_tie = d[5]; m_xie = d[4]; m_pie = d[3];
                    m_tif = m_tif & d[2];
                    m_xif = m_xif & d[1];
                    m_pif = (m_pif & d[0]) | (port_hi != m_ref);
                end
                default: asleep = 1'($urandom);
            endcase
            tick(12);
            chk("R1 R3 R4 R6 random reg", ctrl_rd, model_reg());
            chk("R8 random wake", wake, model_wake());
            chk("R8 random no vector", vec_req, 1'b0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule